// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral built around a 32-bit down-counter. While the counter is enabled it decrements by one on every clock. When it passes through zero it raises an interrupt and starts again from the programmed reload value. If software has not acknowledged that interrupt by the time the count runs out a second time, the block asserts a reset request, provided reset generation is enabled. The reset request is a level. It holds until the block itself is reset.

Software reaches the block through a plain synchronous register port made of an address, a write strobe, write data and combinational read data. A key register guards every other register. Writing the key value 0x1ACCE551 opens the block for writes, and writing any other value closes it again. A healthy system therefore services the watchdog in three steps: unlock, then acknowledge the interrupt (which also restarts the count), then lock again.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the reload register and the count both read 0xFFFFFFFF. Control, raw status, masked status and the key status all read 0. The irq and reset request outputs are low.
- R2: Register offsets are: reload 0x000, live count 0x004 (read only), control 0x008, interrupt acknowledge 0x00C (write only), raw status 0x010, masked status 0x014, key 0xC00. Unmapped reads return 0. Control bit 0 is the count/interrupt enable and bit 1 is the reset enable, and control reads back these two bits.
- R3: A write to the reload register also loads the count with the written value in the same cycle.
- R4: While control bit 0 is set, the count drops by one on each clock. The first decrement happens on the edge after the enabling write.
- R5: On the clock where the count is 0, the count is restored from the reload register and the interrupt becomes pending. With reload value L, irq rises on the (L+1)th edge after enabling.
- R6: Any write to the acknowledge register clears the pending interrupt and restores the count from the reload register.
- R7: Raw status bit 0 shows the pending interrupt regardless of enables. Masked status bit 0 and the irq output show it only while control bit 0 is set. Clearing bit 0 freezes the count.
- R8: An expiry that finds the interrupt already pending while control bit 1 is clear only restores the count. The interrupt stays pending and no reset is requested.
- R9: An expiry that finds the interrupt already pending while control bit 1 is set raises the reset request. The request then stays high, even if control is cleared, until the block is reset.
- R10: Writing 0x1ACCE551 to the key register unlocks the block, and any other value locks it. The key register reads 0 when unlocked and 1 when locked. The block comes out of reset unlocked. While locked, writes to reload, control and acknowledge are ignored.
- R11: With a reload value of 0 and both enables set, irq rises one edge after enabling and the reset request rises on the second edge.
- R12: If an acknowledge write lands on the same edge as the second expiry, the acknowledge wins. No reset is requested, the interrupt is cleared and the count is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt, pending and enabled |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The acknowledge write and the counter's own expiry can land on the same clock edge. The most dangerous case is the second expiry, where that edge decides between recovery and a system reset. The bench programs a reload value of 4 with both enables set and counts nine edges. It then issues the acknowledge so that the write strobe is sampled on the tenth edge, which is exactly when the second expiry would fire. Afterwards it judges that the reset request is still low, that irq has dropped, and that the count reads back the full reload value.

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY = 32'h1ACC_E551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          rst_req
);
  localparam logic [AW-1:0] A_RELOAD = AW'('h000);
  localparam logic [AW-1:0] A_COUNT  = AW'('h004);
  localparam logic [AW-1:0] A_CTRL   = AW'('h008);
  localparam logic [AW-1:0] A_ACK    = AW'('h00C);
  localparam logic [AW-1:0] A_RAW    = AW'('h010);
  localparam logic [AW-1:0] A_MASKED = AW'('h014);
  localparam logic [AW-1:0] A_KEY    = AW'('hC00);

  logic [DW-1:0] reload_q, count_q;
  logic [1:0]    ctrl_q;
  logic          pend_q, locked_q, req_q;

  wire wr_ok   = bus_we && !locked_q;
  wire wr_load = wr_ok && bus_addr == A_RELOAD;
  wire wr_ctrl = wr_ok && bus_addr == A_CTRL;
  wire wr_ack  = wr_ok && bus_addr == A_ACK;
  wire run     = ctrl_q[0];
  wire expire  = run && count_q == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '1;
      count_q  <= '1;
      ctrl_q   <= '0;
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_KEY) locked_q <= (bus_wdata != KEY);
      if (wr_load) reload_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];

      if (wr_load)      count_q <= bus_wdata;
      else if (wr_ack)  count_q <= reload_q;
      else if (expire)  count_q <= reload_q;
      else if (run)     count_q <= count_q - 1'b1;

      if (wr_ack)      pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;

      if (expire && !wr_ack && pend_q && ctrl_q[1]) req_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_RELOAD: bus_rdata = reload_q;
      A_COUNT:  bus_rdata = count_q;
      A_CTRL:   bus_rdata = DW'(ctrl_q);
      A_RAW:    bus_rdata = DW'(pend_q);
      A_MASKED: bus_rdata = DW'(pend_q & run);
      A_KEY:    bus_rdata = DW'(locked_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq     = pend_q & run;
  assign rst_req = req_q;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic        irq,
  input logic        rst_req,
  input logic [31:0] reload_q,
  input logic [31:0] count_q,
  input logic [1:0]  ctrl_q,
  input logic        pend_q,
  input logic        locked_q
);
  // R9
  sticky_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R9
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(pend_q) && $past(ctrl_q[1]) && $past(count_q) == 32'd0);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(count_q) == 32'd0 && $past(ctrl_q[0]));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !locked_q && bus_addr == 12'h00C) |=> !pend_q && !rst_req || $past(rst_req));

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !bus_we) |=> $stable(count_q));

  // R10
  locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_we && bus_addr == 12'h000) |=> $stable(reload_q));

  // R3
  load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && bus_we && bus_addr == 12'h000) |=> count_q == $past(bus_wdata));
endmodule

bind wdog_twostage wdog_twostage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq(irq), .rst_req(rst_req),
  .reload_q(reload_q), .count_q(count_q), .ctrl_q(ctrl_q),
  .pend_q(pend_q), .locked_q(locked_q)
);

// File: tb/wdog_twostage_tb.sv
module wdog_twostage_tb;
  localparam logic [11:0] A_RELOAD = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008,
                          A_ACK = 12'h00C, A_RAW = 12'h010, A_MASKED = 12'h014,
                          A_KEY = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  wdog_twostage u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; bus_we = 1'b0;
    edges(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    do_reset;
    rd(A_RELOAD, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(A_COUNT, v);  chk("R1 count", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
    rd(A_RAW, v);    chk("R1 raw", v, 0);
    rd(A_MASKED, v); chk("R1 masked", v, 0);
    rd(A_KEY, v);    chk("R1 key", v, 0);
    rd(12'h020, v);  chk("R2 unmapped", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
  endtask

  task automatic t_count_expire_ack;
    logic [31:0] v;
    do_reset;
    wr(A_RELOAD, 10);
    rd(A_RELOAD, v); chk("R2 reload readback", v, 10);
    rd(A_COUNT, v);  chk("R3 count loaded", v, 10);
    wr(A_CTRL, 1);
    rd(A_CTRL, v);   chk("R2 ctrl readback", v, 1);
    rd(A_COUNT, v);  chk("R4 no decrement on enable edge", v, 10);
    edges(3);
    rd(A_COUNT, v);  chk("R4 count after 3", v, 7);
    edges(7);
    rd(A_COUNT, v);  chk("R4 count at zero", v, 0);
    chk("R5 irq before expiry", {31'b0, irq}, 0);
    edges(1);
    chk("R5 irq after expiry", {31'b0, irq}, 1);
    rd(A_COUNT, v);  chk("R5 count restored", v, 10);
    wr(A_ACK, 32'h5A);
    chk("R6 irq cleared", {31'b0, irq}, 0);
    rd(A_RAW, v);    chk("R6 raw cleared", v, 0);
    rd(A_COUNT, v);  chk("R6 count restored", v, 10);
    edges(11);
    chk("R5 irq again", {31'b0, irq}, 1);
    rd(A_MASKED, v); chk("R7 masked on", v, 1);
    wr(A_CTRL, 0);
    chk("R7 irq masked", {31'b0, irq}, 0);
    rd(A_RAW, v);    chk("R7 raw still set", v, 1);
    rd(A_MASKED, v); chk("R7 masked off", v, 0);
    rd(A_COUNT, v);  chk("R7 last decrement", v, 9);
    edges(5);
    rd(A_COUNT, v);  chk("R7 count frozen", v, 9);
    wr(A_CTRL, 1);
    edges(10);
    chk("R8 irq held", {31'b0, irq}, 1);
    chk("R8 no reset", {31'b0, rst_req}, 0);
    rd(A_COUNT, v);  chk("R8 count restored", v, 10);
  endtask

  task automatic t_reset_request;
    do_reset;
    wr(A_RELOAD, 5);
    wr(A_CTRL, 3);
    edges(11);
    chk("R9 not yet", {31'b0, rst_req}, 0);
    chk("R9 irq pending", {31'b0, irq}, 1);
    edges(1);
    chk("R9 reset raised", {31'b0, rst_req}, 1);
    wr(A_CTRL, 0);
    edges(3);
    chk("R9 reset sticky", {31'b0, rst_req}, 1);
  endtask

  task automatic t_load_zero;
    do_reset;
    wr(A_RELOAD, 0);
    wr(A_CTRL, 3);
    edges(1);
    chk("R11 irq after one", {31'b0, irq}, 1);
    chk("R11 no reset yet", {31'b0, rst_req}, 0);
    edges(1);
    chk("R11 reset after two", {31'b0, rst_req}, 1);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    do_reset;
    wr(A_RELOAD, 20);
    wr(A_KEY, 1);
    rd(A_KEY, v);    chk("R10 locked reads 1", v, 1);
    wr(A_RELOAD, 99);
    rd(A_RELOAD, v); chk("R10 reload ignored", v, 20);
    rd(A_COUNT, v);  chk("R10 count untouched", v, 20);
    wr(A_CTRL, 3);
    rd(A_CTRL, v);   chk("R10 ctrl ignored", v, 0);
    edges(5);
    rd(A_COUNT, v);  chk("R10 not running", v, 20);
    wr(A_KEY, KEY);
    rd(A_KEY, v);    chk("R10 unlocked reads 0", v, 0);
    wr(A_RELOAD, 99);
    rd(A_RELOAD, v); chk("R10 reload accepted", v, 99);
    wr(A_CTRL, 1);
    edges(100);
    chk("R10 irq up", {31'b0, irq}, 1);
    wr(A_KEY, 32'h1ACC_E550);
    wr(A_ACK, 1);
    rd(A_RAW, v);    chk("R10 ack ignored", v, 1);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    do_reset;
    wr(A_RELOAD, 4);
    wr(A_CTRL, 3);
    edges(9);
    chk("R12 irq pending", {31'b0, irq}, 1);
    rd(A_COUNT, v);  chk("R12 count at zero", v, 0);
    wr(A_ACK, 1);
    chk("R12 no reset", {31'b0, rst_req}, 0);
    chk("R12 irq cleared", {31'b0, irq}, 0);
    rd(A_COUNT, v);  chk("R12 count restored", v, 4);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state;
    t_count_expire_ack;
    t_reset_request;
    t_load_zero;
    t_lock;
    t_collision;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule